// File: doc/BRIEF.md
# Dual-Direction Sample Delay Front End

This block is the input stage of a multirate FIR datapath. It holds two independent delay lines of samples, one advancing upward from its entry stage and one advancing downward, each stepping only when its own shift enable is asserted. A separate bank of tap registers feeds the downstream multipliers. When its own transfer enable is asserted, the bank takes a full parallel snapshot of one delay line, and a select input chooses which line.

Because the two lines run in opposite directions, one line can carry the forward half of a symmetric impulse response and the other the time-reversed half. The same arrangement lets two interleaved sample streams share a single set of taps. The last stage of each line drives an output port, so that several blocks can be chained into a longer filter. Sample width and stage count are parameters, with defaults of 10 bits and 12 stages.

Top module: `sample_delay_front`

## Requirements
- R1: While `rst` is high at a rising clock edge, every stage of both delay lines and every tap register is cleared to zero, so `dout_a`, `dout_b` and all of `taps_o` read zero after that edge.
- R2: When `shift_a_en` is high at a rising edge, stage 0 of line A loads `din_a` and each stage k (k ≥ 1) loads stage k-1. After twelve such shifts, the first sample pushed sits in stage 11 and the last sample pushed sits in stage 0.
- R3: When `shift_b_en` is high at a rising edge, stage 11 of line B loads `din_b` and each stage k (k ≤ 10) loads stage k+1. After twelve such shifts, the first sample pushed sits in stage 0 and the last sample pushed sits in stage 11.
- R4: `dout_a` always shows the content of line A stage 11.
- R5: `dout_b` always shows the content of line B stage 0.
- R6: When a line's shift enable is low at a rising edge, every stage of that line keeps its value.
- R7: When `xfer_en` is high and `xfer_sel_a` is 1 at a rising edge, tap register k loads line A stage k, for all k at once.
- R8: When `xfer_en` is high and `xfer_sel_a` is 0 at a rising edge, tap register k loads line B stage k, for all k at once.
- R9: When `xfer_en` is low at a rising edge, all tap registers keep their values.
- R10: When a transfer and a shift of the selected line happen at the same edge, the tap registers receive that line's contents from before the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din_a | input | 10 | Sample entering line A at stage 0 |
| din_b | input | 10 | Sample entering line B at stage 11 |
| shift_a_en | input | 1 | Shift enable for line A |
| shift_b_en | input | 1 | Shift enable for line B |
| xfer_en | input | 1 | Parallel transfer enable for the tap bank |
| xfer_sel_a | input | 1 | Transfer source: 1 selects line A, 0 selects line B |
| dout_a | output | 10 | Line A stage 11, for cascading |
| dout_b | output | 10 | Line B stage 0, for cascading |
| taps_o | output | 120 | Tap register k at bits [10k+9:10k] |

## Verification
The bench steps through every combination of the two shift enables, the transfer enable and the select, and then runs a long pseudo-random mix of them. After every edge it compares both tail outputs and all twelve taps against an arithmetic model.

Cycles in which a transfer coincides with a shift of the selected line are the most telling case. A design that sampled the lines after the shift would hand the taps a set shifted by one stage.

Directed fills with known ramps pin down the direction of each line. A line wired in the wrong direction would place the ramp reversed in the taps. A swapped select polarity would load the wrong line. An enable that leaked across lines would move a line that should hold. A reset applied in the middle of traffic checks that the asynchronous-looking state still clears on the edge.

// File: rtl/sdf_pkg.sv
`timescale 1ns/1ps
package sdf_pkg;

    localparam int SAMPLE_W_DEF = 10;
    localparam int STAGES_DEF   = 12;

    typedef enum logic {
        DIR_ASCEND  = 1'b0,
        DIR_DESCEND = 1'b1
    } shift_dir_e;

    typedef enum logic {
        SRC_LINE_B = 1'b0,
        SRC_LINE_A = 1'b1
    } tap_src_e;

    // stage where new samples enter a line
    function automatic int entry_stage(shift_dir_e dir, int nstages);
        return (dir == DIR_ASCEND) ? 0 : nstages - 1;
    endfunction

    // stage that leaves the line toward the cascade output
    function automatic int tail_stage(shift_dir_e dir, int nstages);
        return (dir == DIR_ASCEND) ? nstages - 1 : 0;
    endfunction

endpackage

// File: rtl/sdf_shift_chain.sv
`timescale 1ns/1ps
module sdf_shift_chain
    import sdf_pkg::*;
#(
    parameter int         DW  = SAMPLE_W_DEF,
    parameter int         NS  = STAGES_DEF,
    parameter shift_dir_e DIR = DIR_ASCEND
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic [DW-1:0]    din,
    output logic [NS*DW-1:0] stages_o,
    output logic [DW-1:0]    tail_o
);

    localparam int ENTRY = entry_stage(DIR, NS);
    localparam int TAIL  = tail_stage(DIR, NS);

    logic [DW-1:0] stg_q [NS];
    logic [DW-1:0] feed  [NS];

    for (genvar k = 0; k < NS; k++) begin : g_stage
        if (k == ENTRY) begin : g_entry
            assign feed[k] = din;
        end else if (DIR == DIR_ASCEND) begin : g_up
            assign feed[k] = stg_q[k-1];
        end else begin : g_down
            assign feed[k] = stg_q[k+1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stg_q[k] <= '0;
            end else if (shift_en) begin
                stg_q[k] <= feed[k];
            end
        end

        assign stages_o[k*DW +: DW] = stg_q[k];
    end

    assign tail_o = stg_q[TAIL];

    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(stages_o)); // R6

    if (DIR == DIR_ASCEND) begin : g_chk_up
        AST_UP_ENTRY: assert property (@(posedge clk) disable iff (rst)
            shift_en |=> stages_o[0 +: DW] == $past(din)); // R2
        if (NS > 1) begin : g_mv
            AST_UP_MOVE: assert property (@(posedge clk) disable iff (rst)
                shift_en |=> stages_o[DW +: DW] == $past(stages_o[0 +: DW])); // R2
        end
    end else begin : g_chk_down
        AST_DOWN_ENTRY: assert property (@(posedge clk) disable iff (rst)
            shift_en |=> stages_o[(NS-1)*DW +: DW] == $past(din)); // R3
        if (NS > 1) begin : g_mv
            AST_DOWN_MOVE: assert property (@(posedge clk) disable iff (rst)
                shift_en |=> stages_o[0 +: DW] == $past(stages_o[DW +: DW])); // R3
        end
    end

endmodule

// File: rtl/sdf_tap_bank.sv
`timescale 1ns/1ps
module sdf_tap_bank
    import sdf_pkg::*;
#(
    parameter int DW = SAMPLE_W_DEF,
    parameter int NS = STAGES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic             sel_a,
    input  logic [NS*DW-1:0] line_a_i,
    input  logic [NS*DW-1:0] line_b_i,
    output logic [NS*DW-1:0] taps_o
);

    tap_src_e         src;
    logic [NS*DW-1:0] pick;
    logic [NS*DW-1:0] taps_q;

    assign src = tap_src_e'(sel_a);

    always_comb begin
        case (src)
            SRC_LINE_A: pick = line_a_i;
            default:    pick = line_b_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            taps_q <= '0;
        end else if (load_en) begin
            taps_q <= pick;
        end
    end

    assign taps_o = taps_q;

    AST_TAPS_FROM_A: assert property (@(posedge clk) disable iff (rst)
        (load_en && sel_a) |=> taps_o == $past(line_a_i)); // R7
    AST_TAPS_FROM_B: assert property (@(posedge clk) disable iff (rst)
        (load_en && !sel_a) |=> taps_o == $past(line_b_i)); // R8
    AST_TAPS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(taps_o)); // R9

endmodule

// File: rtl/sample_delay_front.sv
`timescale 1ns/1ps
module sample_delay_front
    import sdf_pkg::*;
#(
    parameter int DW = SAMPLE_W_DEF,
    parameter int NS = STAGES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DW-1:0]    din_a,
    input  logic [DW-1:0]    din_b,
    input  logic             shift_a_en,
    input  logic             shift_b_en,
    input  logic             xfer_en,
    input  logic             xfer_sel_a,
    output logic [DW-1:0]    dout_a,
    output logic [DW-1:0]    dout_b,
    output logic [NS*DW-1:0] taps_o
);

    logic [NS*DW-1:0] a_stages;
    logic [NS*DW-1:0] b_stages;

    sdf_shift_chain #(.DW(DW), .NS(NS), .DIR(DIR_ASCEND)) i_line_a (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_a_en),
        .din      (din_a),
        .stages_o (a_stages),
        .tail_o   (dout_a)
    );

    sdf_shift_chain #(.DW(DW), .NS(NS), .DIR(DIR_DESCEND)) i_line_b (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_b_en),
        .din      (din_b),
        .stages_o (b_stages),
        .tail_o   (dout_b)
    );

    sdf_tap_bank #(.DW(DW), .NS(NS)) i_taps (
        .clk      (clk),
        .rst      (rst),
        .load_en  (xfer_en),
        .sel_a    (xfer_sel_a),
        .line_a_i (a_stages),
        .line_b_i (b_stages),
        .taps_o   (taps_o)
    );

    if (NS > 1) begin : g_chk_tail
        AST_TAIL_A: assert property (@(posedge clk) disable iff (rst)
            shift_a_en |=> dout_a == $past(a_stages[(NS-2)*DW +: DW])); // R4
        AST_TAIL_B: assert property (@(posedge clk) disable iff (rst)
            shift_b_en |=> dout_b == $past(b_stages[DW +: DW])); // R5
        AST_XFER_PRESHIFT: assert property (@(posedge clk) disable iff (rst)
            (xfer_en && xfer_sel_a && shift_a_en)
                |=> taps_o[(NS-1)*DW +: DW] == $past(dout_a)); // R10
    end

endmodule

// File: tb/test_sample_delay_front.sv
`timescale 1ns/1ps
module test_sample_delay_front;

    localparam int DW = 10;
    localparam int NS = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DW-1:0]    din_a = '0;
    logic [DW-1:0]    din_b = '0;
    logic             shift_a_en = 1'b0;
    logic             shift_b_en = 1'b0;
    logic             xfer_en = 1'b0;
    logic             xfer_sel_a = 1'b0;
    logic [DW-1:0]    dout_a;
    logic [DW-1:0]    dout_b;
    logic [NS*DW-1:0] taps_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] seed = 16'h1d3f;

    logic [DW-1:0] ma [NS];
    logic [DW-1:0] mb [NS];
    logic [DW-1:0] mc [NS];

    always #2 clk = ~clk;

    sample_delay_front #(.DW(DW), .NS(NS)) i_sample_delay_front (
        .clk(clk), .rst(rst), .din_a(din_a), .din_b(din_b),
        .shift_a_en(shift_a_en), .shift_b_en(shift_b_en),
        .xfer_en(xfer_en), .xfer_sel_a(xfer_sel_a),
        .dout_a(dout_a), .dout_b(dout_b), .taps_o(taps_o)
    );

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [15:0] rnd(input logic [15:0] s);
        return s * 16'd25173 + 16'd13849;
    endfunction

    task automatic check_all(input string ta, input string tb, input string tc);
        check(ta, dout_a, ma[NS-1]);
        check(tb, dout_b, mb[0]);
        for (int k = 0; k < NS; k++) check(tc, taps_o[k*DW +: DW], mc[k]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        for (int k = 0; k < NS; k++) begin ma[k] = '0; mb[k] = '0; mc[k] = '0; end
        #1;
        check_all("R1", "R1", "R1");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cyc(input bit ea, input bit eb, input bit ec, input bit s,
                       input logic [DW-1:0] da, input logic [DW-1:0] db);
        logic [DW-1:0] na [NS];
        logic [DW-1:0] nb [NS];
        logic [DW-1:0] nc [NS];
        string ta, tb, tc;
        @(negedge clk);
        shift_a_en = ea; shift_b_en = eb; xfer_en = ec; xfer_sel_a = s;
        din_a = da; din_b = db;
        @(posedge clk);
        for (int k = 0; k < NS; k++) begin
            nc[k] = ec ? (s ? ma[k] : mb[k]) : mc[k];
            na[k] = ea ? ((k == 0) ? da : ma[k-1]) : ma[k];
            nb[k] = eb ? ((k == NS-1) ? db : mb[k+1]) : mb[k];
        end
        for (int k = 0; k < NS; k++) begin ma[k] = na[k]; mb[k] = nb[k]; mc[k] = nc[k]; end
        ta = ea ? "R4" : "R6";
        tb = eb ? "R5" : "R6";
        if (!ec) tc = "R9";
        else if ((s && ea) || (!s && eb)) tc = "R10";
        else tc = s ? "R7" : "R8";
        #1;
        check_all(ta, tb, tc);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // R2: ramp into line A, first sample must land in stage 11
        for (int k = 0; k < NS; k++) cyc(1, 0, 0, 0, 10'(100 + k), '0);
        cyc(0, 0, 1, 1, '0, '0);
        for (int k = 0; k < NS; k++) check("R2", taps_o[k*DW +: DW], 10'(100 + NS - 1 - k));

        // R3: ramp into line B, first sample must land in stage 0
        for (int k = 0; k < NS; k++) cyc(0, 1, 0, 0, '0, 10'(200 + k));
        cyc(0, 0, 1, 0, '0, '0);
        for (int k = 0; k < NS; k++) check("R3", taps_o[k*DW +: DW], 10'(200 + k));

        // sweep over every enable/select combination
        for (int c = 0; c < 16; c++) begin
            for (int i = 0; i < 30; i++) begin
                seed = rnd(seed);
                cyc(c[0], c[1], c[2], c[3], seed[9:0], seed[15:6]);
            end
        end

        // pseudo-random control mix
        for (int i = 0; i < 1500; i++) begin
            seed = rnd(seed);
            cyc(seed[12], seed[13], seed[14], seed[15], seed[9:0], {seed[4:0], seed[15:11]});
        end

        do_reset();
        for (int i = 0; i < 40; i++) begin
            seed = rnd(seed);
            cyc(seed[15], seed[11], seed[13], seed[14], seed[10:1], seed[9:0]);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule